// File: doc/BRIEF.md
# Pointer Post-Modification Address Unit

This block supplies operand addresses for multiply-accumulate style instructions. It holds two pointer families. The index family has two pointers and two offset registers of its own. The word family has sixteen pointers and a separate pair of offset registers. On each accepted access the block presents the chosen pointer's current value as the operand address. On the same clock edge it writes back that pointer changed by one of five post-modify operations.

The caller picks a family, a pointer, an offset register and a mode for every access. Software sets pointers and offsets through one load port. When a load and a post-modify hit the same pointer in the same cycle, the load takes effect. All registers are 16 bits wide and every sum wraps modulo 2^16.

Top module: `ptr_postmod_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all pointers and all four offset registers to zero, so every pointer reads as 0 afterwards.
- R2: `acc_addr` always shows the selected pointer's value before modification, in the same cycle the selection is driven. Family 0 is the index family and family 1 is the word family.
- R3: Mode 3'b001 adds 2 to the selected pointer and mode 3'b010 subtracts 2. Both wrap modulo 2^16, so 0xFFFF+2 gives 0x0001 and 0x0000-2 gives 0xFFFE.
- R4: Mode 3'b011 adds the offset register chosen by `acc_ofs_sel` and mode 3'b100 subtracts it, with wrap. An index pointer uses only the index offsets. A word pointer uses only the word offsets.
- R5: Mode 3'b000 and the unused codes 3'b101, 3'b110 and 3'b111 leave every pointer unchanged.
- R6: An access changes only the selected pointer. With `acc_valid` low, no pointer changes.
- R7: With `ld_en` high, `ld_data` is written at the clock edge to the register named by `ld_target` and `ld_sel`. The `ld_target` codes are 0 for an index pointer, 1 for a word pointer, 2 for an index offset and 3 for a word offset. The index banks and both offset banks use only `ld_sel[0]`.
- R8: If a load and an accepted access target the same pointer in one cycle, the loaded value is kept. If they target different registers, both take effect.
- R9: For the index family only `acc_ptr_sel[0]` selects the pointer, and the upper select bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access accepted this cycle |
| acc_family | input | 1 | 0 = index family, 1 = word family |
| acc_ptr_sel | input | 4 | Pointer number within the family |
| acc_ofs_sel | input | 1 | Offset register of the family |
| acc_mode | input | 3 | Post-modify mode code |
| acc_addr | output | 16 | Selected pointer value before modification |
| ld_en | input | 1 | Software load strobe |
| ld_target | input | 2 | Register bank to load |
| ld_sel | input | 4 | Entry within the bank |
| ld_data | input | 16 | Value to load |

## Verification
A seeded random stream mixes all eight mode codes across both families, every pointer and both offset selects, with occasional loads that sometimes collide with the access. This separates offset-bank cross-wiring from family selection errors. Directed cases drive values next to 0x0000 and 0xFFFF to expose missing wrap, and run reserved codes and idle cycles to expose spurious writes. Same-pointer and different-pointer load collisions tell load priority apart from a lost access. An index select with its upper bits set shows whether those bits leak into the selection.

// File: rtl/ptrmod_pkg.sv
package ptrmod_pkg;

    localparam int PM_DW      = 16;
    localparam int PM_N_IDX   = 2;
    localparam int PM_N_WRD   = 16;
    localparam int PM_N_OFS   = 2;
    localparam int PM_STEP    = 2;

    typedef enum logic [2:0] {
        PM_KEEP   = 3'd0,
        PM_INC    = 3'd1,
        PM_DEC    = 3'd2,
        PM_ADDOFS = 3'd3,
        PM_SUBOFS = 3'd4
    } pm_mode_e;

    typedef enum logic {
        FAM_IDX = 1'b0,
        FAM_WRD = 1'b1
    } pm_family_e;

    typedef enum logic [1:0] {
        LD_IDX_PTR = 2'd0,
        LD_WRD_PTR = 2'd1,
        LD_IDX_OFS = 2'd2,
        LD_WRD_OFS = 2'd3
    } pm_ld_tgt_e;

    function automatic int pm_selw(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ptr_bank.sv
module ptr_bank
    import ptrmod_pkg::*;
#(
    parameter int DW = 16,
    parameter int N  = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [pm_selw(N)-1:0] wr_sel,
    input  logic [DW-1:0]         wr_data,
    input  logic                  ld_en,
    input  logic [pm_selw(N)-1:0] ld_sel,
    input  logic [DW-1:0]         ld_data,
    output logic [N-1:0][DW-1:0]  q
);
    localparam int SW = pm_selw(N);

    for (genvar e = 0; e < N; e++) begin : g_entry
        logic ld_hit;
        logic wr_hit;
        assign ld_hit = ld_en && (ld_sel == SW'(e));
        assign wr_hit = wr_en && (wr_sel == SW'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                q[e] <= '0;
            end else if (ld_hit) begin
                q[e] <= ld_data;
            end else if (wr_hit) begin
                q[e] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/ptr_step_alu.sv
module ptr_step_alu
    import ptrmod_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] cur,
    input  logic [DW-1:0] ofs,
    input  pm_mode_e      mode,
    output logic [DW-1:0] nxt
);
    localparam logic [DW-1:0] STEP = DW'(PM_STEP);

    always_comb begin
        case (mode)
            PM_INC:    nxt = cur + STEP;
            PM_DEC:    nxt = cur - STEP;
            PM_ADDOFS: nxt = cur + ofs;
            PM_SUBOFS: nxt = cur - ofs;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/ptr_postmod_unit.sv
module ptr_postmod_unit
    import ptrmod_pkg::*;
#(
    parameter int DW    = PM_DW,
    parameter int N_IDX = PM_N_IDX,
    parameter int N_WRD = PM_N_WRD,
    parameter int N_OFS = PM_N_OFS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_valid,
    input  logic                      acc_family,
    input  logic [pm_selw(N_WRD)-1:0] acc_ptr_sel,
    input  logic [pm_selw(N_OFS)-1:0] acc_ofs_sel,
    input  logic [2:0]                acc_mode,
    output logic [DW-1:0]             acc_addr,
    input  logic                      ld_en,
    input  logic [1:0]                ld_target,
    input  logic [pm_selw(N_WRD)-1:0] ld_sel,
    input  logic [DW-1:0]             ld_data
);
    localparam int IDX_SW = pm_selw(N_IDX);
    localparam int WRD_SW = pm_selw(N_WRD);
    localparam int OFS_SW = pm_selw(N_OFS);

    logic [N_IDX-1:0][DW-1:0] idx_q;
    logic [N_WRD-1:0][DW-1:0] wrd_q;
    logic [N_OFS-1:0][DW-1:0] qx_q;
    logic [N_OFS-1:0][DW-1:0] qr_q;

    pm_family_e fam;
    pm_ld_tgt_e ld_tgt;
    pm_mode_e   mode;
    logic [IDX_SW-1:0] idx_sel;
    logic [DW-1:0]     cur_val;
    logic [DW-1:0]     ofs_val;
    logic [DW-1:0]     nxt_val;

    assign fam     = pm_family_e'(acc_family);
    assign ld_tgt  = pm_ld_tgt_e'(ld_target);
    assign mode    = pm_mode_e'(acc_mode);
    assign idx_sel = acc_ptr_sel[IDX_SW-1:0];

    always_comb begin
        if (fam == FAM_WRD) begin
            cur_val = wrd_q[acc_ptr_sel];
            ofs_val = qr_q[acc_ofs_sel];
        end else begin
            cur_val = idx_q[idx_sel];
            ofs_val = qx_q[acc_ofs_sel];
        end
    end

    assign acc_addr = cur_val;

    ptr_step_alu #(.DW(DW)) alu_i (
        .cur  (cur_val),
        .ofs  (ofs_val),
        .mode (mode),
        .nxt  (nxt_val)
    );

    ptr_bank #(.DW(DW), .N(N_IDX)) idx_bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc_valid && fam == FAM_IDX),
        .wr_sel  (idx_sel),
        .wr_data (nxt_val),
        .ld_en   (ld_en && ld_tgt == LD_IDX_PTR),
        .ld_sel  (ld_sel[IDX_SW-1:0]),
        .ld_data (ld_data),
        .q       (idx_q)
    );

    ptr_bank #(.DW(DW), .N(N_WRD)) wrd_bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (acc_valid && fam == FAM_WRD),
        .wr_sel  (acc_ptr_sel[WRD_SW-1:0]),
        .wr_data (nxt_val),
        .ld_en   (ld_en && ld_tgt == LD_WRD_PTR),
        .ld_sel  (ld_sel[WRD_SW-1:0]),
        .ld_data (ld_data),
        .q       (wrd_q)
    );

    ptr_bank #(.DW(DW), .N(N_OFS)) qx_bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (1'b0),
        .wr_sel  ('0),
        .wr_data ('0),
        .ld_en   (ld_en && ld_tgt == LD_IDX_OFS),
        .ld_sel  (ld_sel[OFS_SW-1:0]),
        .ld_data (ld_data),
        .q       (qx_q)
    );

    ptr_bank #(.DW(DW), .N(N_OFS)) qr_bank_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (1'b0),
        .wr_sel  ('0),
        .wr_data ('0),
        .ld_en   (ld_en && ld_tgt == LD_WRD_OFS),
        .ld_sel  (ld_sel[OFS_SW-1:0]),
        .ld_data (ld_data),
        .q       (qr_q)
    );
endmodule

// File: rtl/ptr_postmod_chk.sv
module ptr_postmod_chk
    import ptrmod_pkg::*;
#(
    parameter int DW    = PM_DW,
    parameter int N_IDX = PM_N_IDX,
    parameter int N_WRD = PM_N_WRD,
    parameter int N_OFS = PM_N_OFS
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      acc_valid,
    input logic                      acc_family,
    input logic [pm_selw(N_WRD)-1:0] acc_ptr_sel,
    input logic [pm_selw(N_OFS)-1:0] acc_ofs_sel,
    input logic [2:0]                acc_mode,
    input logic [DW-1:0]             acc_addr,
    input logic                      ld_en,
    input logic [1:0]                ld_target,
    input logic [pm_selw(N_WRD)-1:0] ld_sel,
    input logic [DW-1:0]             ld_data,
    input logic [N_IDX-1:0][DW-1:0]  idx_q,
    input logic [N_WRD-1:0][DW-1:0]  wrd_q,
    input logic [N_OFS-1:0][DW-1:0]  qr_q
);
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> acc_addr == '0); // R1

    AST_WORD_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_family && acc_mode == 3'd1 && !ld_en)
        |=> wrd_q[$past(acc_ptr_sel)] == DW'($past(acc_addr) + DW'(2))); // R3

    AST_INDEX_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_family && acc_mode == 3'd2 && !ld_en)
        |=> idx_q[$past(acc_ptr_sel[0])] == DW'($past(acc_addr) - DW'(2))); // R3

    AST_WORD_OFS_ADD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_family && acc_mode == 3'd3 && !ld_en)
        |=> wrd_q[$past(acc_ptr_sel)] == DW'($past(acc_addr) + $past(qr_q[acc_ofs_sel]))); // R4

    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_mode >= 3'd5 && !ld_en)
        |=> $stable(idx_q) && $stable(wrd_q)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !ld_en) |=> $stable(idx_q) && $stable(wrd_q)); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (ld_en && ld_target == 2'd1)
        |=> wrd_q[$past(ld_sel)] == $past(ld_data)); // R8
endmodule

bind ptr_postmod_unit ptr_postmod_chk #(
    .DW(DW), .N_IDX(N_IDX), .N_WRD(N_WRD), .N_OFS(N_OFS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_family  (acc_family),
    .acc_ptr_sel (acc_ptr_sel),
    .acc_ofs_sel (acc_ofs_sel),
    .acc_mode    (acc_mode),
    .acc_addr    (acc_addr),
    .ld_en       (ld_en),
    .ld_target   (ld_target),
    .ld_sel      (ld_sel),
    .ld_data     (ld_data),
    .idx_q       (idx_q),
    .wrd_q       (wrd_q),
    .qr_q        (qr_q)
);

// File: tb/ptr_postmod_unit_tb_top.sv
module ptr_postmod_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_family = 1'b0;
    logic [3:0]  acc_ptr_sel = '0;
    logic        acc_ofs_sel = 1'b0;
    logic [2:0]  acc_mode = '0;
    logic [15:0] acc_addr;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_target = '0;
    logic [3:0]  ld_sel = '0;
    logic [15:0] ld_data = '0;

    always #5 clk = ~clk;

    ptr_postmod_unit dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_family(acc_family),
        .acc_ptr_sel(acc_ptr_sel), .acc_ofs_sel(acc_ofs_sel), .acc_mode(acc_mode),
        .acc_addr(acc_addr), .ld_en(ld_en), .ld_target(ld_target),
        .ld_sel(ld_sel), .ld_data(ld_data)
    );

    logic [15:0] m_idx [2];
    logic [15:0] m_wrd [16];
    logic [15:0] m_qx  [2];
    logic [15:0] m_qr  [2];

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    function automatic logic [15:0] model_next(input logic [15:0] cur,
                                               input logic [15:0] ofs,
                                               input logic [2:0]  m);
        case (m)
            3'd1:    return cur + 16'd2;
            3'd2:    return cur - 16'd2;
            3'd3:    return cur + ofs;
            3'd4:    return cur - ofs;
            default: return cur;
        endcase
    endfunction

    function automatic logic [15:0] model_cur(input logic f, input logic [3:0] p);
        return f ? m_wrd[p] : m_idx[p[0]];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            m_idx[i] = '0; m_qx[i] = '0; m_qr[i] = '0;
        end
        for (int i = 0; i < 16; i++) m_wrd[i] = '0;
    endtask

    task automatic step(input logic v, input logic f, input logic [3:0] p,
                        input logic o, input logic [2:0] m,
                        input logic le, input logic [1:0] lt,
                        input logic [3:0] ls, input logic [15:0] ld,
                        input string tag);
        logic [15:0] exp_addr;
        logic [15:0] nv;
        bit          hit;
        @(negedge clk);
        acc_valid = v; acc_family = f; acc_ptr_sel = p; acc_ofs_sel = o;
        acc_mode = m; ld_en = le; ld_target = lt; ld_sel = ls; ld_data = ld;
        #1;
        exp_addr = model_cur(f, p);
        n_vec++;
        if (acc_addr !== exp_addr) begin
            n_fail++;
            $display("FAIL %s: acc_addr=%h expected=%h", tag, acc_addr, exp_addr);
        end
        nv = model_next(exp_addr, f ? m_qr[o] : m_qx[o], m);
        if (v) begin
            hit = le && ((f && lt == 2'd1 && ls == p) || (!f && lt == 2'd0 && ls[0] == p[0]));
            if (!hit) begin
                if (f) m_wrd[p] = nv; else m_idx[p[0]] = nv;
            end
        end
        if (le) begin
            case (lt)
                2'd0: m_idx[ls[0]] = ld;
                2'd1: m_wrd[ls]    = ld;
                2'd2: m_qx[ls[0]]  = ld;
                default: m_qr[ls[0]] = ld;
            endcase
        end
    endtask

    task automatic peek(input logic f, input logic [3:0] p, input string tag);
        step(1'b0, f, p, 1'b0, 3'd1, 1'b0, 2'd0, 4'd0, 16'h0, tag);
    endtask

    task automatic load(input logic [1:0] lt, input logic [3:0] ls, input logic [15:0] d);
        step(1'b0, 1'b0, 4'd0, 1'b0, 3'd0, 1'b1, lt, ls, d, "R7");
    endtask

    task automatic access(input logic f, input logic [3:0] p, input logic o,
                          input logic [2:0] m, input string tag);
        step(1'b1, f, p, o, m, 1'b0, 2'd0, 4'd0, 16'h0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        model_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every pointer and every offset reads zero after reset
        for (int i = 0; i < 2; i++) peek(1'b0, 4'(i), "R1");
        for (int i = 0; i < 16; i++) peek(1'b1, 4'(i), "R1");
        access(1'b1, 4'd0, 1'b1, 3'd3, "R1");
        access(1'b0, 4'd0, 1'b0, 3'd3, "R1");
        peek(1'b1, 4'd0, "R1");
        peek(1'b0, 4'd0, "R1");

        // R3: wrap on +2 and -2
        load(2'd1, 4'd5, 16'hFFFF);
        peek(1'b1, 4'd5, "R7");
        access(1'b1, 4'd5, 1'b0, 3'd1, "R2");
        peek(1'b1, 4'd5, "R3");
        load(2'd0, 4'd1, 16'h0000);
        access(1'b0, 4'd1, 1'b0, 3'd2, "R2");
        peek(1'b0, 4'd1, "R3");

        // R4: offsets, family separation
        load(2'd2, 4'd1, 16'h1234);
        load(2'd3, 4'd0, 16'h8000);
        load(2'd0, 4'd0, 16'hF000);
        access(1'b0, 4'd0, 1'b1, 3'd3, "R4");
        peek(1'b0, 4'd0, "R4");
        load(2'd1, 4'd3, 16'h9000);
        access(1'b1, 4'd3, 1'b0, 3'd4, "R4");
        peek(1'b1, 4'd3, "R4");
        access(1'b0, 4'd0, 1'b0, 3'd3, "R4");
        peek(1'b0, 4'd0, "R4");

        // R5: keep and reserved codes
        for (int m = 0; m < 8; m++) begin
            if (m == 0 || m >= 5) begin
                access(1'b1, 4'd3, 1'b0, 3'(m), "R5");
                peek(1'b1, 4'd3, "R5");
            end
        end

        // R6: idle access and isolation of neighbours
        step(1'b0, 1'b1, 4'd5, 1'b0, 3'd1, 1'b0, 2'd0, 4'd0, 16'h0, "R6");
        peek(1'b1, 4'd5, "R6");
        access(1'b1, 4'd4, 1'b0, 3'd1, "R6");
        peek(1'b1, 4'd5, "R6");
        peek(1'b1, 4'd3, "R6");

        // R8: same-pointer collision and disjoint collision
        load(2'd1, 4'd7, 16'h1000);
        step(1'b1, 1'b1, 4'd7, 1'b0, 3'd1, 1'b1, 2'd1, 4'd7, 16'hABCD, "R8");
        peek(1'b1, 4'd7, "R8");
        step(1'b1, 1'b1, 4'd7, 1'b0, 3'd1, 1'b1, 2'd1, 4'd8, 16'h4242, "R8");
        peek(1'b1, 4'd7, "R8");
        peek(1'b1, 4'd8, "R8");

        // R9: upper select bits ignored for the index family
        load(2'd0, 4'd1, 16'h0777);
        peek(1'b0, 4'b1011, "R9");
        access(1'b0, 4'b1110, 1'b0, 3'd1, "R9");
        peek(1'b0, 4'd0, "R9");
        peek(1'b0, 4'd1, "R9");

        // Random mix of all families, modes and loads
        for (int k = 0; k < 3000; k++) begin
            logic        rv, rf, ro, rle;
            logic [3:0]  rp, rls;
            logic [2:0]  rm;
            logic [1:0]  rlt;
            logic [15:0] rd;
            rv  = ($urandom % 4) != 0;
            rf  = 1'($urandom);
            rp  = 4'($urandom);
            ro  = 1'($urandom);
            rm  = 3'($urandom);
            rle = ($urandom % 4) == 0;
            rlt = 2'($urandom);
            rls = (($urandom % 3) == 0) ? rp : 4'($urandom);
            rd  = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
            step(rv, rf, rp, ro, rm, rle, rlt, rls, rd, "R2 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule